// File: doc/BRIEF.md
# Projective X/Z Montgomery Ladder Engine over GF(2^m)

This block runs the main loop of scalar point multiplication on a binary-field elliptic curve. It works in projective X/Z coordinates and keeps two working points, (X1,Z1) and (X2,Z2). A start pulse captures the scalar k, the affine x coordinate of the base point and the curve constant b. The block then runs one iteration for each scalar bit below the leading one. When it finishes, X1/Z1 represent kP and X2/Z2 represent (k+1)P, ready for a later coordinate conversion stage.

Every iteration uses the same datapath: a differential addition into (X2,Z2) and a doubling into (X1,Z1). The scalar never selects a branch. It only decides whether the two coordinate pairs swap places. There is one swap before the first iteration, and one after each iteration whenever two adjacent scalar bits differ, so operand addressing does not depend on the key. Each iteration has two steps. Each step runs three bit-serial field multipliers in parallel. Squarings are combinational. The step-one products are kept in buffer registers and feed step two directly.

Top module: `ladder_unit`

## Requirements
- R1: On an accepted start, the registers are loaded as X1=x, Z1=1, X2=x^4+b, Z2=x^2. If bit (L-1) of k is 1, where L is the position of the leading one of k, the two pairs are loaded swapped (X1 with X2, Z1 with Z2).
- R2: The loop runs for i = L-1 down to 0, which is L iterations. If k=1 there are no iterations and the outputs are the unswapped R1 values.
- R3: When the block finishes, (x1,z1,x2,z2) equal the values of the conditional ladder. Each bit k_i, from L-1 down to 0, updates the registers as follows, with Z3=(X1·Z2+X2·Z1)^2:
  - if k_i=0: X2=x·Z3+(X1·Z2)(X2·Z1), Z2=Z3, X1=X1^4+b·Z1^4, Z1=X1^2·Z1^2;
  - if k_i=1: the same updates with the subscripts 1 and 2 exchanged.
- R4: Field elements are m-bit polynomial-basis vectors, with bit j the coefficient of t^j, reduced by t^163+t^7+t^6+t^3+1 at the default m=163.
- R5: For a nontrivial start with leading-one position L, done is high in the state that follows the 2·m·L-th rising edge after the edge that accepts start.
- R6: done is high for exactly one cycle per accepted start. After reset, done and trivial are 0 and all coordinate outputs are 0.
- R7: start is ignored while an operation is running. The result and its timing match a run with no extra start.
- R8: Between the done pulse and the next accepted start, the coordinate outputs do not change.
- R9: If k=0 or x=0, the block raises done and trivial together in the cycle after the accepted start. It runs no iterations, and the coordinates hold the unswapped R1 values. For every other start, trivial stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| k | input | M | Scalar |
| px | input | M | Base point affine x |
| pb | input | M | Curve constant b |
| done | output | 1 | One-cycle completion pulse |
| trivial | output | 1 | With done: k or x was zero |
| x1 | output | M | Final X1 (kP) |
| z1 | output | M | Final Z1 (kP) |
| x2 | output | M | Final X2 ((k+1)P) |
| z2 | output | M | Final Z2 ((k+1)P) |

## Verification
The bench computes expected coordinates with a branching ladder that never swaps and uses its own LSB-first multiplier. Any mistake in the initial swap, the per-iteration swap rule or the final swap therefore shows up as wrong coordinates.

The bench targets the following corner cases:
- k=2 and k=3 separate the two initial-swap choices and the final-bit swap on a single iteration. A design that ignores bit 0 in the final swap would return (k+1)P in place of kP.
- k=1 checks that no loop runs at all.
- k=0 and x=0 check the trivial flag.
- A full-width scalar checks the top loop count. An off-by-one in the leading-one search would change both the latency and the result.
- A start pulse injected mid-run would corrupt the operands if the block accepted it.

// File: rtl/ladder_unit.sv
module ladder_unit #(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = {{(M-8){1'b0}}, 8'hC9}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] k,
  input  logic [M-1:0] px,
  input  logic [M-1:0] pb,
  output logic         done,
  output logic         trivial,
  output logic [M-1:0] x1,
  output logic [M-1:0] z1,
  output logic [M-1:0] x2,
  output logic [M-1:0] z2
);
  localparam int IW = $clog2(M);
  localparam int NL = 3;
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {IDLE, STEP1, STEP2} state_t;

  function automatic logic [M-1:0] xt(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  function automatic logic [M-1:0] sq(input logic [M-1:0] v);
    logic [2*M-2:0] r;
    r = '0;
    for (int i = 0; i < M; i++) r[2*i] = v[i];
    for (int i = 2*M-2; i >= M; i--)
      if (r[i]) begin
        r[i] = 1'b0;
        r[i-M +: M] = r[i-M +: M] ^ POLY;
      end
    return r[M-1:0];
  endfunction

  function automatic logic [IW-1:0] lead_of(input logic [M-1:0] v);
    logic [IW-1:0] p;
    p = '0;
    for (int i = 0; i < M; i++) if (v[i]) p = IW'(i);
    return p;
  endfunction

  state_t        state;
  logic [IW-1:0] cnt, idx;
  logic [M-1:0]  kr, xr, br;
  logic [M-1:0]  rx1, rz1, rx2, rz2;
  logic [M-1:0]  t1, t2, z3, t3;
  logic [M-1:0]  acc  [NL];
  logic [M-1:0]  opa  [NL];
  logic [M-1:0]  opb  [NL];
  logic [M-1:0]  macc [NL];
  logic          busy;

  assign busy = (state != IDLE);
  assign x1 = rx1;
  assign z1 = rz1;
  assign x2 = rx2;
  assign z2 = rz2;

  always_comb begin
    if (state == STEP2) begin
      opa[0] = t1;  opb[0] = t2;
      opa[1] = xr;  opb[1] = z3;
      opa[2] = br;  opb[2] = sq(sq(rz1));
    end else begin
      opa[0] = rx1; opb[0] = rz2;
      opa[1] = rx2; opb[1] = rz1;
      opa[2] = rx1; opb[2] = rz1;
    end
  end

  logic [IW-1:0] bsel;
  assign bsel = IW'(M-1) - cnt;

  for (genvar j = 0; j < NL; j++) begin : g_lane
    assign macc[j] = xt(acc[j]) ^ (opb[j][bsel] ? opa[j] : '0);
  end

  logic [IW-1:0] lead;
  logic          zero, sw0, load_swap;
  logic [M-1:0]  ix2, iz2;
  assign lead      = lead_of(k);
  assign zero      = (k == '0) || (px == '0);
  assign sw0       = (lead != '0) ? k[lead - IW'(1)] : 1'b0;
  assign load_swap = !zero && sw0;
  assign iz2       = sq(px);
  assign ix2       = sq(iz2) ^ pb;

  logic [M-1:0] nx1, nx2;
  logic         swi, lastc;
  assign nx2   = macc[0] ^ macc[1];
  assign nx1   = macc[2] ^ sq(sq(rx1));
  assign swi   = kr[idx] ^ ((idx == '0) ? 1'b0 : kr[idx - IW'(1)]);
  assign lastc = (cnt == IW'(M-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt <= '0;  idx <= '0;
      kr <= '0;   xr <= '0;  br <= '0;
      rx1 <= '0;  rz1 <= '0; rx2 <= '0; rz2 <= '0;
      t1 <= '0;   t2 <= '0;  z3 <= '0;  t3 <= '0;
      for (int j = 0; j < NL; j++) acc[j] <= '0;
      done <= 1'b0;
      trivial <= 1'b0;
    end else begin
      done <= 1'b0;
      trivial <= 1'b0;
      case (state)
        IDLE: if (start) begin
          kr <= k;  xr <= px;  br <= pb;
          rx1 <= load_swap ? ix2 : px;
          rz1 <= load_swap ? iz2 : ONE;
          rx2 <= load_swap ? px  : ix2;
          rz2 <= load_swap ? ONE : iz2;
          cnt <= '0;
          for (int j = 0; j < NL; j++) acc[j] <= '0;
          if (zero || lead == '0) begin
            done <= 1'b1;
            trivial <= zero;
          end else begin
            idx <= lead - IW'(1);
            state <= STEP1;
          end
        end
        STEP1: begin
          for (int j = 0; j < NL; j++) acc[j] <= lastc ? '0 : macc[j];
          cnt <= lastc ? '0 : cnt + IW'(1);
          if (lastc) begin
            t1 <= macc[0];
            t2 <= macc[1];
            z3 <= sq(macc[0] ^ macc[1]);
            t3 <= sq(macc[2]);
            state <= STEP2;
          end
        end
        STEP2: begin
          for (int j = 0; j < NL; j++) acc[j] <= lastc ? '0 : macc[j];
          cnt <= lastc ? '0 : cnt + IW'(1);
          if (lastc) begin
            rx1 <= swi ? nx2 : nx1;
            rz1 <= swi ? z3  : t3;
            rx2 <= swi ? nx1 : nx2;
            rz2 <= swi ? t3  : z3;
            if (idx == '0) begin
              done <= 1'b1;
              state <= IDLE;
            end else begin
              idx <= idx - IW'(1);
              state <= STEP1;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ladder_unit_chk.sv
module ladder_unit_chk #(
  parameter int M = 163
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic [M-1:0] k,
  input logic [M-1:0] px,
  input logic [M-1:0] kr,
  input logic         done,
  input logic         trivial,
  input logic [M-1:0] x1,
  input logic [M-1:0] z1,
  input logic [M-1:0] x2,
  input logic [M-1:0] z2
);
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_trivial_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trivial |-> done);

  assert_zero_trivial_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (k == '0 || px == '0)) |=> (done && trivial));

  assert_load_unit_z_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (z1 == ONE || z2 == ONE));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(kr));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x1) && $stable(z1) && $stable(x2) && $stable(z2)));
endmodule

bind ladder_unit ladder_unit_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .k(k), .px(px),
  .kr(kr), .done(done), .trivial(trivial),
  .x1(x1), .z1(z1), .x2(x2), .z2(z2)
);

// File: tb/tb_ladder_unit.sv
`timescale 1ns/1ps
module tb_ladder_unit;
  localparam int M = 163;
  localparam logic [M-1:0] P = 163'hC9;
  localparam logic [M-1:0] ONE = 163'h1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [M-1:0] k = '0, px = '0, pb = '0;
  logic done, trivial;
  logic [M-1:0] x1, z1, x2, z2;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ladder_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .k(k), .px(px), .pb(pb),
    .done(done), .trivial(trivial), .x1(x1), .z1(z1), .x2(x2), .z2(z2));

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r ^= a;
      a = {a[M-2:0], 1'b0} ^ (a[M-1] ? P : '0);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] gsq(input logic [M-1:0] a);
    return gmul(a, a);
  endfunction

  function automatic int lead(input logic [M-1:0] v);
    int p = -1;
    for (int i = 0; i < M; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [191:0] w;
    for (int i = 0; i < 6; i++) w[i*32 +: 32] = $urandom;
    return w[M-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ref_ladder(input logic [M-1:0] kk, xx, bb,
                            output logic [M-1:0] a1, c1, a2, c2);
    logic [M-1:0] z3v, m1, m2, d1, d2;
    a1 = xx; c1 = ONE; a2 = gsq(gsq(xx)) ^ bb; c2 = gsq(xx);
    for (int i = lead(kk) - 1; i >= 0; i--) begin
      m1 = gmul(a1, c2); m2 = gmul(a2, c1);
      z3v = gsq(m1 ^ m2);
      if (kk[i]) begin
        d1 = gsq(gsq(a2)) ^ gmul(bb, gsq(gsq(c2)));
        d2 = gmul(gsq(a2), gsq(c2));
        a1 = gmul(xx, z3v) ^ gmul(m1, m2); c1 = z3v; a2 = d1; c2 = d2;
      end else begin
        d1 = gsq(gsq(a1)) ^ gmul(bb, gsq(gsq(c1)));
        d2 = gmul(gsq(a1), gsq(c1));
        a2 = gmul(xx, z3v) ^ gmul(m1, m2); c2 = z3v; a1 = d1; c1 = d2;
      end
    end
  endtask

  task automatic run_case(input logic [M-1:0] kk, xx, bb, input bit poke, input string nm);
    logic [M-1:0] e1, f1, e2, f2;
    int n, lat;
    bit triv;
    triv = (kk == '0) || (xx == '0);
    if (triv) begin
      e1 = xx; f1 = ONE; e2 = gsq(gsq(xx)) ^ bb; f2 = gsq(xx);
      lat = 0;
    end else begin
      ref_ladder(kk, xx, bb, e1, f1, e2, f2);
      lat = 2 * M * lead(kk);
    end
    @(negedge clk);
    k = kk; px = xx; pb = bb; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done) begin
      if (poke && n == 5) begin start = 1; k = ~kk; px = ~xx; pb = ~bb; end
      else if (poke && n == 6) begin start = 0; k = kk; px = xx; pb = bb; end
      @(negedge clk);
      n++;
    end
    chk(n == lat, {nm, " R5 latency"}, M'(n), M'(lat));
    chk(trivial == triv, {nm, " R9 trivial flag"}, M'(trivial), M'(triv));
    chk(x1 == e1, {nm, poke ? " R7 x1" : " R3 x1"}, x1, e1);
    chk(z1 == f1, {nm, " R3 z1"}, z1, f1);
    chk(x2 == e2, {nm, " R3 x2"}, x2, e2);
    chk(z2 == f2, {nm, " R3 z2"}, z2, f2);
    @(negedge clk);
    chk(done == 0, {nm, " R6 done single cycle"}, M'(done), '0);
    repeat (3) @(negedge clk);
    chk(x1 == e1 && z1 == f1 && x2 == e2 && z2 == f2, {nm, " R8 hold"}, x1, e1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog: done never seen, actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] kk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done == 0 && trivial == 0, "R6 reset flags", M'({done, trivial}), '0);
    chk(x1 == '0 && z1 == '0 && x2 == '0 && z2 == '0, "R6 reset coords", x1 | z1 | x2 | z2, '0);
    rst_n = 1;
    @(negedge clk);
    run_case('0, rnd(), rnd(), 0, "k0 R9");
    run_case(M'(5), '0, rnd(), 0, "x0 R9");
    run_case(M'(1), rnd(), rnd(), 0, "k1 R1 R2");
    run_case(M'(2), rnd(), rnd(), 0, "k2 R1");
    run_case(M'(3), rnd(), rnd(), 0, "k3 R2");
    for (int t = 0; t < 5; t++) begin
      int m = 2 + int'($urandom % 15);
      kk = rnd() & ((ONE << m) - ONE);
      kk[m] = 1'b1;
      run_case(kk, rnd(), rnd(), 0, "rand R3 R4");
    end
    kk = rnd() & ((ONE << 12) - ONE);
    kk[12] = 1'b1;
    run_case(kk, rnd(), rnd(), 1, "poke R7");
    kk = rnd();
    kk[M-1] = 1'b1;
    run_case(kk, rnd(), rnd(), 0, "full R2 R4");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule